// File: doc/BRIEF.md
# Process-Tagged Page-Indexed Data Cache

This block is a direct-mapped data cache whose set is picked from address bits that lie entirely inside the page offset. A lookup can therefore read its arrays from the untranslated address while a translation unit computes the physical page number in parallel. In the following cycle the stored physical tag is compared with that page number. Each line also holds the identifier of the process that filled it, so a line never hits for any other process. As a result, a context switch needs no flush.

The default geometry is 32-bit addresses, 4 KB pages and 16-byte lines, which gives 256 lines. The line count is derived from the page size and the line size, so capacity always equals exactly one page. The returned data is one 32-bit word of the line, picked by address bits 3:2. Misses are handled outside the block: the requester writes the line back through the refill port, together with its physical page number and process ID. A single-cycle global invalidate clears every valid bit.

Top module: `vipt_pid_cache`

## Requirements
- R1: After reset every line is invalid, `respValid` is low, and the first lookup to any address misses.
- R2: A lookup accepted at a clock edge produces `respValid` high during the next cycle only. `xlatePpn` is sampled in that response cycle.
- R3: The line index is `lookupVaddr[11:4]` and the returned word is `lookupVaddr[3:2]` (word w is `refillLine[32*w+31:32*w]`). Bits 31:12 of the virtual address have no effect on the result.
- R4: A response hits only if the line is valid and its stored page number equals `xlatePpn` in the response cycle.
- R5: A response hits only if the stored process ID equals the `lookupPid` given with the lookup.
- R6: A refill at index `refillVaddr[11:4]` stores the line, page number and process ID, and marks the line valid at that edge.
- R7: `invalidateAll` clears every valid bit at one edge, so later lookups miss until a refill.
- R8: When `invalidateAll` and a refill share an edge, the refilled line ends up valid and every other line is invalid.
- R9: A lookup that shares an edge with a refill or invalidate sees the array contents from before that edge.
- R10: `respData` is zero whenever the response is a miss or there is no response, and `respHit` is low when `respValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Start a lookup this edge |
| lookupVaddr | input | 32 | Virtual address of the lookup |
| lookupPid | input | 8 | Process ID of the lookup |
| xlatePpn | input | 20 | Translated physical page number, valid in the response cycle |
| refillValid | input | 1 | Write a line this edge |
| refillVaddr | input | 32 | Address that supplies the refill index |
| refillPpn | input | 20 | Physical page number stored as tag |
| refillPid | input | 8 | Process ID stored with the line |
| refillLine | input | 128 | Line data |
| invalidateAll | input | 1 | Clear all valid bits this edge |
| respValid | output | 1 | Response present this cycle |
| respHit | output | 1 | Response is a hit |
| respData | output | 32 | Selected word on a hit, zero otherwise |

## Verification
The bench aims at lookups that match on the tag but not on the process ID, and on the process ID but not on the tag. A design that compares only one of the two would report false hits. It changes the upper virtual bits while keeping the index, so a design that indexes or tags with virtual page bits would miss. It places refills and invalidates on the same edge as a lookup, and on the same edge as each other. Wrong read-before-write ordering, or wrong precedence between clear and fill, would return data the model does not expect. Random traffic over a small set of indices, page numbers and IDs then checks every response against the behavioural model.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  typedef struct packed {
    logic readArr;
    logic writeLine;
    logic clearAll;
    logic respLive;
  } vpcStrobe_t;
endpackage

// File: rtl/vpc_ctrl.sv
module vpc_ctrl
  import vpc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lookupValid,
  input  logic       refillValid,
  input  logic       invalidateAll,
  output vpcStrobe_t strb
);
  logic stageLive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageLive <= 1'b0;
    else       stageLive <= lookupValid;
  end

  always_comb begin
    strb.readArr   = lookupValid;
    strb.writeLine = refillValid;
    strb.clearAll  = invalidateAll;
    strb.respLive  = stageLive;
  end
endmodule

// File: rtl/vpc_datapath.sv
module vpc_datapath
  import vpc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int OFF_BITS  = 4,
  parameter int WORD_W    = 32,
  parameter int PID_W     = 8,
  localparam int IDX_BITS = PAGE_BITS - OFF_BITS,
  localparam int LINES    = 1 << IDX_BITS,
  localparam int TAG_W    = ADDR_W - PAGE_BITS,
  localparam int LINE_W   = 8 << OFF_BITS,
  localparam int WORDS    = LINE_W / WORD_W,
  localparam int WSEL_W   = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  vpcStrobe_t        strb,
  input  logic [ADDR_W-1:0] lookupVaddr,
  input  logic [PID_W-1:0]  lookupPid,
  input  logic [TAG_W-1:0]  xlatePpn,
  input  logic [ADDR_W-1:0] refillVaddr,
  input  logic [TAG_W-1:0]  refillPpn,
  input  logic [PID_W-1:0]  refillPid,
  input  logic [LINE_W-1:0] refillLine,
  output logic              respHit,
  output logic [WORD_W-1:0] respData
);
  localparam int WSEL_LO = OFF_BITS - WSEL_W;

  logic [LINE_W-1:0] dataArr [LINES];
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [PID_W-1:0]  pidArr  [LINES];
  logic [LINES-1:0]  validBits;

  logic [IDX_BITS-1:0] lkIdx, rfIdx;
  logic [WSEL_W-1:0]   lkWsel;
  assign lkIdx  = lookupVaddr[PAGE_BITS-1:OFF_BITS];
  assign rfIdx  = refillVaddr[PAGE_BITS-1:OFF_BITS];
  assign lkWsel = lookupVaddr[OFF_BITS-1:WSEL_LO];

  logic [LINE_W-1:0] rdLine;
  logic [TAG_W-1:0]  rdTag;
  logic [PID_W-1:0]  rdPid, s1Pid;
  logic [WSEL_W-1:0] s1Wsel;
  logic              rdValid;

  // Array write and synchronous read; old content is read on a shared edge.
  always_ff @(posedge clk) begin
    if (strb.writeLine) begin
      dataArr[rfIdx] <= refillLine;
      tagArr[rfIdx]  <= refillPpn;
      pidArr[rfIdx]  <= refillPid;
    end
    if (strb.readArr) begin
      rdLine <= dataArr[lkIdx];
      rdTag  <= tagArr[lkIdx];
      rdPid  <= pidArr[lkIdx];
      s1Pid  <= lookupPid;
      s1Wsel <= lkWsel;
    end
  end

  // Valid bits: clear first, so a refill on the same edge survives.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validBits <= '0;
      rdValid   <= 1'b0;
    end else begin
      if (strb.readArr) rdValid <= validBits[lkIdx];
      if (strb.clearAll && strb.writeLine) begin
        validBits        <= '0;
        validBits[rfIdx] <= 1'b1;
      end else if (strb.clearAll) begin
        validBits <= '0;
      end else if (strb.writeLine) begin
        validBits[rfIdx] <= 1'b1;
      end
    end
  end

  logic [WORD_W-1:0] lineWords [WORDS];
  for (genvar g = 0; g < WORDS; g++) begin : gWord
    assign lineWords[g] = rdLine[g*WORD_W +: WORD_W];
  end

  logic tagEq, pidEq;
  assign tagEq    = (rdTag == xlatePpn);
  assign pidEq    = (rdPid == s1Pid);
  assign respHit  = strb.respLive && rdValid && tagEq && pidEq;
  assign respData = respHit ? lineWords[s1Wsel] : '0;

  assert_refill_sets_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeLine |=> validBits[$past(rfIdx)]);

  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearAll && !strb.writeLine) |=> (validBits == '0));

  assert_clear_with_fill_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearAll && strb.writeLine) |=> ($countones(validBits) == 1));

  assert_pid_on_hit_R5: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> (rdPid == $past(lookupPid)));

  assert_tag_on_hit_R4: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> (rdTag == xlatePpn));
endmodule

// File: rtl/vipt_pid_cache.sv
module vipt_pid_cache
  import vpc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int OFF_BITS  = 4,
  parameter int WORD_W    = 32,
  parameter int PID_W     = 8,
  localparam int TAG_W    = ADDR_W - PAGE_BITS,
  localparam int LINE_W   = 8 << OFF_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupVaddr,
  input  logic [PID_W-1:0]  lookupPid,
  input  logic [TAG_W-1:0]  xlatePpn,
  input  logic              refillValid,
  input  logic [ADDR_W-1:0] refillVaddr,
  input  logic [TAG_W-1:0]  refillPpn,
  input  logic [PID_W-1:0]  refillPid,
  input  logic [LINE_W-1:0] refillLine,
  input  logic              invalidateAll,
  output logic              respValid,
  output logic              respHit,
  output logic [WORD_W-1:0] respData
);
  vpcStrobe_t strb;

  vpc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid),
    .refillValid(refillValid), .invalidateAll(invalidateAll), .strb(strb)
  );

  vpc_datapath #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .OFF_BITS(OFF_BITS),
    .WORD_W(WORD_W), .PID_W(PID_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .lookupVaddr(lookupVaddr), .lookupPid(lookupPid), .xlatePpn(xlatePpn),
    .refillVaddr(refillVaddr), .refillPpn(refillPpn), .refillPid(refillPid),
    .refillLine(refillLine), .respHit(respHit), .respData(respData)
  );

  assign respValid = strb.respLive;

  assert_resp_timing_R2: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(lookupValid));

  assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> (!respHit && respData == '0));
endmodule

// File: tb/vipt_pid_cache_tb.sv
module vipt_pid_cache_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic         lookupValid = 0, refillValid = 0, invalidateAll = 0;
  logic [31:0]  lookupVaddr = 0, refillVaddr = 0;
  logic [7:0]   lookupPid = 0, refillPid = 0;
  logic [19:0]  xlatePpn = 0, refillPpn = 0;
  logic [127:0] refillLine = 0;
  logic         respValid, respHit;
  logic [31:0]  respData;

  vipt_pid_cache u_dut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVaddr(lookupVaddr),
    .lookupPid(lookupPid), .xlatePpn(xlatePpn), .refillValid(refillValid),
    .refillVaddr(refillVaddr), .refillPpn(refillPpn), .refillPid(refillPid),
    .refillLine(refillLine), .invalidateAll(invalidateAll),
    .respValid(respValid), .respHit(respHit), .respData(respData)
  );

  int errors = 0, checks = 0;

  // Behavioural model
  bit [127:0] mLine [256];
  bit [19:0]  mTag  [256];
  bit [7:0]   mPid  [256];
  bit         mValid[256];

  // Pending lookup snapshot
  bit pendV = 0, pV = 0;
  bit [19:0] pT; bit [7:0] pP, pLkPid; bit [31:0] pW; string pTag;

  // Drive set for the next tick
  bit dLv, dRv, dInv; bit [31:0] dVa, dRva; bit [7:0] dPid, dRpid;
  bit [19:0] dPpn, dRppn; bit [127:0] dRline;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clearDrive();
    dLv = 0; dRv = 0; dInv = 0; dVa = 0; dRva = 0; dPid = 0; dRpid = 0;
    dPpn = 0; dRppn = 0; dRline = 0;
  endtask

  task automatic tick(input string tag);
    bit expHit; bit [31:0] expData; int idx;
    @(negedge clk);
    xlatePpn = dPpn;
    #1;
    if (pendV) begin
      expHit  = pV && (pT == dPpn) && (pP == pLkPid);
      expData = expHit ? pW : 32'h0;
      chk(respValid === 1'b1, "R2", "respValid", {31'b0, respValid}, 32'h1);
      chk(respHit === expHit, pTag, "respHit", {31'b0, respHit}, {31'b0, expHit});
      chk(respData === expData, pTag, "respData", respData, expData);
    end else begin
      chk(respValid === 1'b0 && respHit === 1'b0 && respData === 32'h0, "R10",
          "idle outputs", {respValid, respHit, respData[29:0]}, 32'h0);
    end
    pendV = dLv;
    if (dLv) begin
      idx = int'(dVa[11:4]);
      pV = mValid[idx]; pT = mTag[idx]; pP = mPid[idx];
      pW = mLine[idx][32*dVa[3:2] +: 32];
      pLkPid = dPid; pTag = tag;
    end
    if (dInv) for (int i = 0; i < 256; i++) mValid[i] = 0;
    if (dRv) begin
      idx = int'(dRva[11:4]);
      mLine[idx] = dRline; mTag[idx] = dRppn; mPid[idx] = dRpid; mValid[idx] = 1;
    end
    lookupValid = dLv; lookupVaddr = dVa; lookupPid = dPid;
    refillValid = dRv; refillVaddr = dRva; refillPpn = dRppn; refillPid = dRpid;
    refillLine = dRline; invalidateAll = dInv;
    clearDrive();
  endtask

  task automatic lk(input bit [31:0] va, input bit [7:0] pid);
    dLv = 1; dVa = va; dPid = pid;
  endtask

  task automatic rf(input bit [31:0] va, input bit [19:0] ppn, input bit [7:0] pid,
                    input bit [127:0] line);
    dRv = 1; dRva = va; dRppn = ppn; dRpid = pid; dRline = line;
  endtask

  localparam bit [127:0] LINE_A = 128'hDDDD0003_CCCC0002_BBBB0001_AAAA0000;
  localparam bit [127:0] LINE_B = 128'h44444444_33333333_22222222_11111111;

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clearDrive();
    for (int i = 0; i < 256; i++) mValid[i] = 0;
    repeat (3) @(negedge clk);
    chk(respValid === 1'b0 && respHit === 1'b0, "R1", "reset outputs",
        {30'b0, respValid, respHit}, 32'h0);
    rstN = 1'b1;
    tick("R1");
    lk(32'h0000_0050, 8'd7); tick("R1");              // index 5 empty
    rf(32'h0000_0050, 20'h12345, 8'd7, LINE_A); tick("R6");
    lk(32'h0000_0058, 8'd7); tick("R6");             // word 2
    dPpn = 20'h12345; lk(32'hFFFF_F05C, 8'd7); tick("R3"); // upper bits differ, word 3
    dPpn = 20'h12345; lk(32'h0000_0050, 8'd7); tick("R4"); // next: wrong ppn
    dPpn = 20'h12346; lk(32'h0000_0054, 8'd8); tick("R5"); // next: wrong pid
    dPpn = 20'h12345; tick("R2");
    // lookup with refill of new content to same index on same edge
    lk(32'h0000_0054, 8'd7); rf(32'h0000_0050, 20'h12345, 8'd7, LINE_B); tick("R9");
    dPpn = 20'h12345; lk(32'h0000_0054, 8'd7); tick("R6");
    // lookup together with invalidate: sees old
    dPpn = 20'h12345; lk(32'h0000_0050, 8'd7); dInv = 1; tick("R9");
    dPpn = 20'h12345; lk(32'h0000_0050, 8'd7); tick("R7");
    rf(32'h0000_0A00, 20'h00ABC, 8'd3, LINE_A); tick("R6");
    dPpn = 20'h12345; dInv = 1; rf(32'h0000_0B00, 20'h00BBB, 8'd4, LINE_B); tick("R8");
    lk(32'h0000_0B0C, 8'd4); tick("R8");
    dPpn = 20'h00BBB; lk(32'h0000_0A00, 8'd3); tick("R8");
    dPpn = 20'h00ABC; tick("R7");
    // random traffic over a small space
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 1) == 1)
        lk({12'($urandom_range(0, 4095)), 20'(0)} | 32'({$urandom_range(0, 7), 4'h0})
           | 32'($urandom_range(0, 15)), 8'($urandom_range(0, 2)));
      if ($urandom_range(0, 3) == 0)
        rf(32'({$urandom_range(0, 7), 4'h0}), 20'($urandom_range(0, 2)),
           8'($urandom_range(0, 2)), {$urandom, $urandom, $urandom, $urandom});
      if ($urandom_range(0, 99) == 0) dInv = 1;
      dPpn = 20'($urandom_range(0, 2));
      tick("R4");
    end
    tick("R2");
    tick("R2");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule